// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers four shared, active-low PCI interrupt lines onto a bank of sixteen legacy interrupt request inputs. Each PCI line has a route register that names its target IRQ. A pair of trigger-mode registers marks each IRQ as edge- or level-sensitive. The block merges the steered PCI lines with sixteen edge-style legacy sources. Each resulting request is qualified by its trigger mode and driven out as a registered IRQ request vector. The interrupt controller sits downstream and is not part of this block.

Software programs the block over a byte-wide configuration bus. A write is decoded in the cycle it is presented and held as a pending operation. The pending operation takes effect on the following clock edge. The operation register is the block's state machine, and it is in exactly one of these states:
- `OP_IDLE`: no write pending.
- `OP_ROUTE`: a route write to a line that exists.
- `OP_BADLINE`: a route write to a line index of 4 to 7.
- `OP_ELCR_LO`: a write to the low trigger-mode register.
- `OP_ELCR_HI`: a write to the high trigger-mode register.
- `OP_STATUS`: a write to the status register.

On every clock edge the machine moves to the state decoded from the bus, or to `OP_IDLE` when no write strobe is present. The state it leaves is committed on that same edge. Back-to-back writes therefore need no handshake.

An accepted route also switches its target IRQ into level mode. Routes to IRQ numbers that cannot be shared are refused, as are routes to line indices that do not exist. A refusal raises a sticky error flag.

Top module: `irq_steer`

## Requirements
- R1: After reset:
  - every route register reads 0x80, meaning routing is disabled;
  - both trigger-mode registers read 0x00, meaning all IRQs are in edge mode;
  - the status register reads 0x00;
  - `irq_req` is all zero.
- R2: Addresses 0x0 to 0x3 hold the route registers for PCI lines 0 to 3. A route write with bit 7 clear and a value of 3 to 7, 9 to 12, 14 or 15 is stored. The stored value reads back from the second clock edge after the write is presented.
- R3: A route value with bit 7 clear that equals 0, 1, 2, 8 or 13, or that exceeds 15, is refused. The route register keeps its old value and status bit 0 (the error flag) is set.
- R4: A write to addresses 0x4 to 0x7 (line index above 3) is refused. No route register or trigger-mode register changes, and the error flag is set.
- R5: An accepted route to IRQ n sets bit n of the low trigger-mode register (address 0x8) for n from 3 to 7. For n from 9 to 15 it sets bit n-8 of the high trigger-mode register (address 0x9). All other bits are left unchanged.
- R6: A route value with bit 7 set is always accepted and stored as written. It disables that line's routing and leaves both trigger-mode registers unchanged.
- R7: A direct write to the trigger-mode registers stores only the writable bits: mask 0xF8 at address 0x8 and 0xDE at address 0x9. The bits for IRQ 0, 1, 2, 8 and 13 always read 0.
- R8: The error flag is sticky. Only a write to address 0xA with data bit 0 set clears it. A write there with bit 0 clear leaves it set.
- R9: An enabled route asserts its target IRQ source while the PCI line is low. Several lines steered to one IRQ are wire-ORed.
- R10: In edge mode, a rising source raises `irq_req[n]` for exactly one cycle, starting at the first clock edge after the rise, however long the source stays high.
- R11: In level mode, `irq_req[n]` equals the source as sampled at the previous clock edge. It stays high for as long as the source does.
- R12: Each legacy source `legacy_irq[n]` is ORed into IRQ n's source together with any PCI lines steered there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| pci_int_n | input | 4 | Active-low shared PCI interrupt lines |
| legacy_irq | input | 16 | Active-high legacy interrupt sources |
| irq_req | output | 16 | Qualified IRQ requests to the interrupt controller |

## Verification
The assertions check the following on every cycle:
- a route register holds either a disabled value or a shareable IRQ number;
- a refused line index raises the flag without touching any route;
- an accepted route leaves its IRQ in level mode;
- the error flag only drops on a clear operation;
- an edge-mode output is never high two cycles running;
- a level-mode output tracks its source.

Only the bench's scenarios show the rest:
- the read-back register values;
- the register masks;
- the wire-OR of two lines sharing one IRQ;
- the interaction between legacy sources and steered lines under concrete pin patterns.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int NLINE = 4;
    localparam int NIRQ  = 16;
    localparam int AW    = 4;
    localparam int DW    = 8;

    localparam logic [AW-1:0] A_ELCR_LO = 4'h8;
    localparam logic [AW-1:0] A_ELCR_HI = 4'h9;
    localparam logic [AW-1:0] A_STATUS  = 4'hA;

    localparam logic [DW-1:0] ROUTE_OFF    = 8'h80;
    localparam logic [DW-1:0] ELCR_LO_MASK = 8'hF8;
    localparam logic [DW-1:0] ELCR_HI_MASK = 8'hDE;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ROUTE,
        OP_BADLINE,
        OP_ELCR_LO,
        OP_ELCR_HI,
        OP_STATUS
    } cfg_op_e;

    function automatic logic irq_shareable(input logic [DW-1:0] v);
        return (v < 8'd16) && !(v inside {8'd0, 8'd1, 8'd2, 8'd8, 8'd13});
    endfunction

endpackage

// File: rtl/irq_steer_cfg.sv
module irq_steer_cfg
    import irq_steer_pkg::*;
#(
    parameter int NL = NLINE,
    parameter int NI = NIRQ
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [DW-1:0]          cfg_wdata,
    output logic [DW-1:0]          cfg_rdata,
    output logic [NL-1:0][DW-1:0]  route_o,
    output logic [NI-1:0]          level_o,
    output logic                   err_o,
    output cfg_op_e                op_o,
    output logic [DW-1:0]          opdata_o
);

    localparam int LW = (NL > 1) ? $clog2(NL) : 1;

    cfg_op_e                op_q, op_d;
    logic [DW-1:0]          data_q;
    logic [LW-1:0]          line_q;
    logic [NL-1:0][DW-1:0]  route_q;
    logic [DW-1:0]          elcr_lo_q, elcr_hi_q;
    logic                   err_q;

    // decode of the bus into the next pending operation
    always_comb begin
        op_d = OP_IDLE;
        if (cfg_wr) begin
            if (!cfg_addr[3]) begin
                op_d = (int'(cfg_addr[2:0]) < NL) ? OP_ROUTE : OP_BADLINE;
            end else if (cfg_addr == A_ELCR_LO) begin
                op_d = OP_ELCR_LO;
            end else if (cfg_addr == A_ELCR_HI) begin
                op_d = OP_ELCR_HI;
            end else if (cfg_addr == A_STATUS) begin
                op_d = OP_STATUS;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            data_q <= '0;
            line_q <= '0;
        end else begin
            op_q   <= op_d;
            data_q <= cfg_wdata;
            line_q <= cfg_addr[LW-1:0];
        end
    end

    // commit of the pending operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) route_q[i] <= ROUTE_OFF;
            elcr_lo_q <= '0;
            elcr_hi_q <= '0;
            err_q     <= 1'b0;
        end else begin
            unique case (op_q)
                OP_IDLE: ;
                OP_ROUTE: begin
                    if (data_q[7]) begin
                        route_q[line_q] <= data_q;
                    end else if (irq_shareable(data_q)) begin
                        route_q[line_q] <= data_q;
                        if (data_q[3]) elcr_hi_q[data_q[2:0]] <= 1'b1;
                        else           elcr_lo_q[data_q[2:0]] <= 1'b1;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                OP_BADLINE: err_q     <= 1'b1;
                OP_ELCR_LO: elcr_lo_q <= data_q & ELCR_LO_MASK;
                OP_ELCR_HI: elcr_hi_q <= data_q & ELCR_HI_MASK;
                OP_STATUS:  if (data_q[0]) err_q <= 1'b0;
            endcase
        end
    end

    // read mux
    always_comb begin
        cfg_rdata = '0;
        if (!cfg_addr[3]) begin
            if (int'(cfg_addr[2:0]) < NL) cfg_rdata = route_q[cfg_addr[LW-1:0]];
        end else if (cfg_addr == A_ELCR_LO) begin
            cfg_rdata = elcr_lo_q;
        end else if (cfg_addr == A_ELCR_HI) begin
            cfg_rdata = elcr_hi_q;
        end else if (cfg_addr == A_STATUS) begin
            cfg_rdata = {{(DW-1){1'b0}}, err_q};
        end
    end

    assign route_o  = route_q;
    assign level_o  = {elcr_hi_q, elcr_lo_q};
    assign err_o    = err_q;
    assign op_o     = op_q;
    assign opdata_o = data_q;

endmodule

// File: rtl/irq_steer_merge.sv
module irq_steer_merge
    import irq_steer_pkg::*;
#(
    parameter int NL = NLINE,
    parameter int NI = NIRQ
) (
    input  logic [NL-1:0][DW-1:0] route_i,
    input  logic [NL-1:0]         pci_int_n,
    input  logic [NI-1:0]         legacy_irq,
    output logic [NI-1:0]         src_o
);

    for (genvar n = 0; n < NI; n++) begin : g_irq
        always_comb begin
            src_o[n] = legacy_irq[n];
            for (int i = 0; i < NL; i++) begin
                if (!pci_int_n[i] && !route_i[i][7] &&
                    (route_i[i][6:0] == 7'(n))) begin
                    src_o[n] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_steer_qual.sv
module irq_steer_qual
    import irq_steer_pkg::*;
#(
    parameter int NI = NIRQ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] src_i,
    input  logic [NI-1:0] level_i,
    output logic [NI-1:0] irq_o
);

    for (genvar n = 0; n < NI; n++) begin : g_q
        logic src_d;
        logic req_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_d <= 1'b0;
                req_q <= 1'b0;
            end else begin
                src_d <= src_i[n];
                req_q <= level_i[n] ? src_i[n] : (src_i[n] & ~src_d);
            end
        end
        assign irq_o[n] = req_q;
    end

endmodule

// File: rtl/irq_steer.sv
module irq_steer
    import irq_steer_pkg::*;
#(
    parameter int NL = NLINE,
    parameter int NI = NIRQ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [3:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic [NL-1:0] pci_int_n,
    input  logic [NI-1:0] legacy_irq,
    output logic [NI-1:0] irq_req
);

    logic [NL-1:0][DW-1:0] route;
    logic [NI-1:0]         level;
    logic [NI-1:0]         src;
    logic                  err;
    cfg_op_e               op;
    logic [DW-1:0]         opdata;

    irq_steer_cfg #(.NL(NL), .NI(NI)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .route_o   (route),
        .level_o   (level),
        .err_o     (err),
        .op_o      (op),
        .opdata_o  (opdata)
    );

    irq_steer_merge #(.NL(NL), .NI(NI)) u_merge (
        .route_i    (route),
        .pci_int_n  (pci_int_n),
        .legacy_irq (legacy_irq),
        .src_o      (src)
    );

    irq_steer_qual #(.NI(NI)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .level_i (level),
        .irq_o   (irq_req)
    );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
    import irq_steer_pkg::*;
#(
    parameter int NL = NLINE,
    parameter int NI = NIRQ
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NL-1:0][DW-1:0] route,
    input logic [NI-1:0]         level,
    input logic [NI-1:0]         src,
    input logic                  err,
    input cfg_op_e               op,
    input logic [DW-1:0]         opdata,
    input logic [NI-1:0]         irq_req
);

    for (genvar i = 0; i < NL; i++) begin : g_line
        AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            route[i][7] || irq_shareable(route[i])); // R3
    end

    AST_BADLINE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BADLINE) |=> (err && $stable(route) && $stable(level))); // R4

    AST_ROUTE_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROUTE && !opdata[7] && irq_shareable(opdata))
        |=> level[$past(opdata[3:0])]); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(op == OP_STATUS && opdata[0])) |=> err); // R8

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & $past(irq_req) & ~level & ~$past(level)) == '0)); // R10

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & $past(level)) == ($past(src) & $past(level)))); // R11

endmodule

bind irq_steer irq_steer_chk #(.NL(NL), .NI(NI)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .route   (route),
    .level   (level),
    .src     (src),
    .err     (err),
    .op      (op),
    .opdata  (opdata),
    .irq_req (irq_req)
);

// File: tb/irq_steer_bench.sv
`timescale 1ns/1ps
module irq_steer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_int_n = 4'hF;
    logic [15:0] legacy_irq = '0;
    logic [15:0] irq_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_steer u_irq_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .pci_int_n  (pci_int_n),
        .legacy_irq (legacy_irq),
        .irq_req    (irq_req)
    );

    // {pci_int_n, legacy_irq, expected irq_req} after one edge from idle
    localparam logic [35:0] VEC [8] = '{
        {4'b1110, 16'h0000, 16'h0020},
        {4'b1101, 16'h0000, 16'h0800},
        {4'b1011, 16'h0000, 16'h0000},
        {4'b0111, 16'h0000, 16'h0200},
        {4'b0000, 16'h0000, 16'h0A20},
        {4'b1111, 16'h0010, 16'h0010},
        {4'b1110, 16'h0020, 16'h0020},
        {4'b1111, 16'h8001, 16'h8001}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, {8'h00, cfg_rdata}, {8'h00, exp});
    endtask

    task automatic idle_inputs();
        pci_int_n = 4'hF; legacy_irq = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(20.0 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 4; i++) read_check("R1 route", 4'(i), 8'h80);
        read_check("R1 elcr lo", 4'h8, 8'h00);
        read_check("R1 elcr hi", 4'h9, 8'h00);
        read_check("R1 status", 4'hA, 8'h00);
        check("R1 irq_req", irq_req, 16'h0000);

        // R2 / R5 valid routes
        cfg_write(4'h0, 8'd5);
        read_check("R2 line0", 4'h0, 8'h05);
        read_check("R5 lo bit5", 4'h8, 8'h20);
        cfg_write(4'h1, 8'd11);
        read_check("R2 line1", 4'h1, 8'h0B);
        read_check("R5 hi bit3", 4'h9, 8'h08);

        // R3 refused values
        cfg_write(4'h2, 8'd13);
        read_check("R3 line2 kept", 4'h2, 8'h80);
        read_check("R3 err set", 4'hA, 8'h01);
        cfg_write(4'hA, 8'h00);
        read_check("R8 err sticky", 4'hA, 8'h01);
        cfg_write(4'hA, 8'h01);
        read_check("R8 err cleared", 4'hA, 8'h00);
        cfg_write(4'h3, 8'd16);
        read_check("R3 value16 kept", 4'h3, 8'h80);
        read_check("R3 value16 err", 4'hA, 8'h01);
        cfg_write(4'hA, 8'h01);
        cfg_write(4'h3, 8'd8);
        read_check("R3 irq8 kept", 4'h3, 8'h80);
        read_check("R3 irq8 err", 4'hA, 8'h01);
        cfg_write(4'hA, 8'h01);

        // R4 bad line index
        cfg_write(4'h5, 8'd3);
        read_check("R4 err", 4'hA, 8'h01);
        read_check("R4 line0", 4'h0, 8'h05);
        read_check("R4 line1", 4'h1, 8'h0B);
        read_check("R4 lo", 4'h8, 8'h20);
        cfg_write(4'hA, 8'h01);

        cfg_write(4'h3, 8'd9);
        read_check("R5 hi bit1", 4'h9, 8'h0A);

        // R6 disable value
        cfg_write(4'h2, 8'h8F);
        read_check("R6 stored", 4'h2, 8'h8F);
        read_check("R6 lo same", 4'h8, 8'h20);
        read_check("R6 hi same", 4'h9, 8'h0A);
        read_check("R6 no err", 4'hA, 8'h00);

        // R7 masks
        cfg_write(4'h8, 8'hFF);
        read_check("R7 lo mask", 4'h8, 8'hF8);
        cfg_write(4'h9, 8'hFF);
        read_check("R7 hi mask", 4'h9, 8'hDE);
        cfg_write(4'h8, 8'h20);
        cfg_write(4'h9, 8'h0A);

        // vector table: R9 R12 R10 R11
        foreach (VEC[k]) begin
            @(negedge clk);
            pci_int_n = VEC[k][35:32];
            legacy_irq = VEC[k][31:16];
            @(negedge clk);
            check($sformatf("R9/R12 vec%0d", k), irq_req, VEC[k][15:0]);
            idle_inputs();
        end

        // R10 edge held high
        @(negedge clk);
        legacy_irq = 16'h0010;
        @(negedge clk);
        check("R10 pulse", irq_req, 16'h0010);
        @(negedge clk);
        check("R10 pulse ends", irq_req, 16'h0000);
        @(negedge clk);
        check("R10 stays low", irq_req, 16'h0000);
        idle_inputs();

        // R11 level held
        pci_int_n = 4'b1110;
        @(negedge clk);
        check("R11 level 1", irq_req, 16'h0020);
        repeat (3) @(negedge clk);
        check("R11 level held", irq_req, 16'h0020);
        pci_int_n = 4'hF;
        @(negedge clk);
        check("R11 level drop", irq_req, 16'h0000);

        // R9 wire-OR of two lines on IRQ5
        cfg_write(4'h2, 8'd5);
        pci_int_n = 4'b1011;
        @(negedge clk);
        check("R9 line2 only", irq_req, 16'h0020);
        pci_int_n = 4'b1010;
        @(negedge clk);
        check("R9 both", irq_req, 16'h0020);
        pci_int_n = 4'b1110;
        @(negedge clk);
        check("R9 line0 only", irq_req, 16'h0020);
        pci_int_n = 4'b1111;
        @(negedge clk);
        check("R9 none", irq_req, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule